// File: doc/BRIEF.md
# Synchronous Burst SRAM Bank Controller

This block is a clocked controller for a two-bank, flow-through synchronous burst SRAM, with the storage array modelled inside it. On each rising clock edge it samples the address, two active-low bank enables, an active-low global write and three burst strobes. The strobes are a processor address strobe, a controller address strobe and a burst advance. From these it chooses one of four actions: start a new access, continue a burst, hold the burst in a wait state, or deselect.

A burst covers four words. Only the low two address bits are generated inside the block. The upper bits keep the value registered when the burst started. The visiting order is linear or interleaved, chosen by a static mode input. Reads are flow-through: the stored word at the registered address appears on the data output in the same cycle, with no output register. Write data is stored on the edge that carries the write command.

An asynchronous active-low output enable and a per-bank snooze input gate the data drivers. The tri-state data bus is split into an output word and a drive-enable flag. When the controller strobe is tied low and the other two strobes are tied high, every cycle becomes an independent single-word access (synchronous-only use).

Top module: `sbsram_ctrl`

## Requirements
- R1: Address, enables, global write and strobes take effect only at a rising clock edge. During a continued burst, the value on `addr_in` has no influence on the word read.
- R2: When `ads_p_n`=0 and exactly one bit of `bank_en_n` is 0, a read burst starts at `addr_in` in that bank, whatever `gw_n` and `ads_c_n` are. No write takes place. Bit 0 low selects bank 0, and bit 1 low selects bank 1.
- R3: When `ads_c_n`=0, `ads_p_n`=1 and exactly one enable is low, the new address is loaded. `gw_n`=0 makes the cycle a write of `wdata` on that edge, and `gw_n`=1 makes it a read.
- R4: When `ads_c_n`=0 and `ads_p_n`=1 with both enables high (or both low), the cycle deselects. `dq_oe` is 0, and later cycles with both strobes high stay deselected.
- R5: When both strobes are high and `adv_n`=0 during an active burst, the counter steps to the next address. The cycle is a write if `gw_n`=0 and a read otherwise.
- R6: When both strobes are high and `adv_n`=1 during an active burst, the address is held and the access repeats at it.
- R7: Upper address bits keep the registered start value. The burst count wraps after four words back to the start address.
- R8: With `interleave`=0 the k-th word (k=0..3) is at low bits (start+k) mod 4. With `interleave`=1 it is at start XOR k.
- R9: When `oe_n`=1, `dq_oe` is 0 even during a read cycle.
- R10: A bank whose `snooze` bit is 1 ignores writes and drives no data. The other bank keeps working.
- R11: With `ads_c_n` held at 0 and `ads_p_n`/`adv_n` held at 1, every cycle accesses a fresh address. Read data is valid in the cycle after the sampling edge (flow-through).
- R12: All 72 bits of the word (64 data bits plus 8 per-byte parity bits) are written by a global write and returned on read.
- R13: A synchronous reset (`rst`=1) leaves both banks deselected with `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | External word address |
| bank_en_n | input | 2 | Active-low bank enables, bit i for bank i |
| gw_n | input | 1 | Active-low global write |
| ads_p_n | input | 1 | Active-low processor address strobe (read start) |
| ads_c_n | input | 1 | Active-low controller address strobe (load or deselect) |
| adv_n | input | 1 | Active-low burst advance |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 2 | Per-bank active-high sleep |
| wdata | input | DW | Write word (data and parity) |
| dq_out | output | DW | Read word, zero when not driven |
| dq_oe | output | 1 | Data driver enable (0 means high impedance) |

## Verification
Every cycle, the assertions check the strobe decode. A processor start must give an active read with the count at zero. A controller strobe with no single enable must deselect. Advance must add one to the count, and a wait must leave the count and upper address unchanged. They also check that a high output enable or a snoozed bank never leaves the drivers on, and that the first burst word equals the start address. Only the bench scenarios can show that the right data comes back: the linear and interleaved orders over real stored words, the wrap after four words, and that a processor-strobe start with the write input low stores nothing. Likewise only the bench can show that writes to a snoozed bank are lost while the other bank keeps serving data.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Registered burst state shared between the decoder and the top.
  typedef struct packed {
    logic       active;  // a bank is selected
    logic       wr;      // current cycle is a write
    logic       bank;    // selected bank index
    logic [1:0] base;    // low address bits at burst start
    logic [1:0] cnt;     // burst position 0..3
  } burst_state_t;
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq (
  input  logic [1:0] base,
  input  logic [1:0] cnt,
  input  logic       interleave,
  output logic [1:0] low
);
  assign low = interleave ? (base ^ cnt) : (base + cnt);

  always_comb begin
    if (cnt == 2'd0) begin
      // R8: the first word of any burst is the external start address
      assert_first_is_start_R8: assert (low == base);
    end
  end
endmodule

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
(
  input  burst_state_t cur,
  input  logic         ads_p_n,
  input  logic         ads_c_n,
  input  logic         adv_n,
  input  logic         gw_n,
  input  logic [1:0]   bank_en_n,
  input  logic [1:0]   snooze,
  input  logic [1:0]   addr_lo,
  output burst_state_t nxt,
  output logic         load
);
  logic one_sel;
  logic sel_bank;

  assign one_sel  = (bank_en_n == 2'b01) || (bank_en_n == 2'b10);
  assign sel_bank = bank_en_n[0];

  always_comb begin
    nxt  = cur;
    load = 1'b0;
    if (!ads_p_n && one_sel) begin
      // processor strobe: read-only start, gated by the enables
      load       = !snooze[sel_bank];
      nxt.active = !snooze[sel_bank];
      nxt.wr     = 1'b0;
      nxt.bank   = sel_bank;
      nxt.base   = addr_lo;
      nxt.cnt    = 2'd0;
    end else if (!ads_c_n) begin
      if (one_sel && !snooze[sel_bank]) begin
        load       = 1'b1;
        nxt.active = 1'b1;
        nxt.wr     = !gw_n;
        nxt.bank   = sel_bank;
        nxt.base   = addr_lo;
        nxt.cnt    = 2'd0;
      end else begin
        nxt.active = 1'b0;
        nxt.wr     = 1'b0;
      end
    end else if (cur.active) begin
      nxt.wr = !gw_n;
      if (!adv_n) nxt.cnt = cur.cnt + 2'd1;
    end
  end
endmodule

// File: rtl/sbs_bank_array.sv
module sbs_bank_array #(
  parameter int AW = 8,
  parameter int DW = 72
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // flow-through: asynchronous read port
  assign rdata = mem[raddr];
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 8,
  parameter int LANEW = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [AW-1:0]               addr_in,
  input  logic [1:0]                  bank_en_n,
  input  logic                        gw_n,
  input  logic                        ads_p_n,
  input  logic                        ads_c_n,
  input  logic                        adv_n,
  input  logic                        interleave,
  input  logic                        oe_n,
  input  logic [1:0]                  snooze,
  input  logic [LANES*(LANEW+1)-1:0]  wdata,
  output logic [LANES*(LANEW+1)-1:0]  dq_out,
  output logic                        dq_oe
);
  localparam int DW    = LANES * (LANEW + 1);
  localparam int HIW   = AW - 2;
  localparam int NBANK = 2;

  burst_state_t  st, nxt;
  logic          load;
  logic [HIW-1:0] hi;
  logic [1:0]    cur_low, nxt_low;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;
  logic [DW-1:0] rd_word [NBANK];

  sbs_cmd_decode u_dec (
    .cur(st), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n),
    .gw_n(gw_n), .bank_en_n(bank_en_n), .snooze(snooze),
    .addr_lo(addr_in[1:0]), .nxt(nxt), .load(load)
  );

  sbs_burst_seq u_seq_cur (.base(st.base),  .cnt(st.cnt),  .interleave(interleave), .low(cur_low));
  sbs_burst_seq u_seq_nxt (.base(nxt.base), .cnt(nxt.cnt), .interleave(interleave), .low(nxt_low));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
      hi <= '0;
    end else begin
      st <= nxt;
      if (load) hi <= addr_in[AW-1:2];
    end
  end

  assign rd_addr = {hi, cur_low};
  assign wr_addr = {(load ? addr_in[AW-1:2] : hi), nxt_low};
  assign wr_en   = !rst && nxt.active && nxt.wr && !snooze[nxt.bank];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sbs_bank_array #(.AW(AW), .DW(DW)) u_arr (
      .clk(clk), .we(wr_en && (nxt.bank == g[0])), .waddr(wr_addr),
      .wdata(wdata), .raddr(rd_addr), .rdata(rd_word[g])
    );
  end

  assign dq_oe  = st.active && !st.wr && !oe_n && !snooze[st.bank];
  assign dq_out = dq_oe ? rd_word[st.bank] : '0;

  // R2: processor strobe with a single enable opens a read burst at count 0
  assert_proc_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!ads_p_n && (bank_en_n == 2'b01 || bank_en_n == 2'b10) && !snooze[bank_en_n[0]])
    |=> (st.active && !st.wr && st.cnt == 2'd0));

  // R4: controller strobe without a single enable deselects
  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    (ads_p_n && !ads_c_n && (bank_en_n == 2'b11 || bank_en_n == 2'b00))
    |=> (!st.active && !dq_oe));

  // R5: advance steps the burst count by one
  assert_advance_step_R5: assert property (@(posedge clk) disable iff (rst)
    (st.active && ads_p_n && ads_c_n && !adv_n)
    |=> (st.cnt == $past(st.cnt) + 2'd1));

  // R6: wait keeps position and upper address
  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (st.active && ads_p_n && ads_c_n && adv_n)
    |=> (st.cnt == $past(st.cnt) && hi == $past(hi)));

  // R9: high output enable keeps drivers off
  assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R10: a snoozed bank never drives
  assert_snooze_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    snooze[st.bank] |-> !dq_oe);

  // R13: reset leaves the block deselected
  assert_reset_idle_R13: assert property (@(posedge clk)
    rst |=> (!st.active && !dq_oe));
endmodule

// File: tb/sbsram_ctrl_bench.sv
`timescale 1ns/1ps
module sbsram_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 72;

  logic clk = 1'b0;
  logic rst, gw_n, ads_p_n, ads_c_n, adv_n, interleave, oe_n;
  logic [AW-1:0] addr_in;
  logic [1:0] bank_en_n, snooze;
  logic [DW-1:0] wdata, dq_out;
  logic dq_oe;

  always #4 clk = ~clk;

  sbsram_ctrl #(.AW(AW)) u_sbsram_ctrl (
    .clk(clk), .rst(rst), .addr_in(addr_in), .bank_en_n(bank_en_n),
    .gw_n(gw_n), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n),
    .interleave(interleave), .oe_n(oe_n), .snooze(snooze),
    .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    bit            drv;
    logic [DW-1:0] d;
    string         tag;
  } item_t;

  item_t exp_q[$];
  item_t cur_item;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] pat(input int b, input int a);
    logic [63:0] body;
    body = (64'(a) * 64'h0102_0304_0506_0709) ^ (b != 0 ? 64'hA5C3_0FF0_5A3C_9966 : 64'h3C5A_F00F_C3A5_6699);
    return {8'(a * 7 + b * 113 + 1), body};
  endfunction

  function automatic logic [1:0] en_of(input int b);
    return (b != 0) ? 2'b01 : 2'b10;
  endfunction

  // driver: applies one cycle of inputs and queues the expected result
  task automatic cyc(input logic pn, input logic cn, input logic av, input logic gw,
                     input logic [1:0] en, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input bit drv, input logic [DW-1:0] ed, input string tag);
    item_t t;
    @(negedge clk);
    ads_p_n = pn; ads_c_n = cn; adv_n = av; gw_n = gw;
    bank_en_n = en; addr_in = a; wdata = wd;
    t.drv = drv; t.d = ed; t.tag = tag;
    exp_q.push_back(t);
    @(posedge clk);
    #3;
  endtask

  task automatic swr(input int b, input int a, input logic [DW-1:0] wd, input string tag);
    cyc(1, 0, 1, 0, en_of(b), AW'(a), wd, 0, '0, tag);
  endtask

  task automatic srd(input int b, input int a, input bit drv, input logic [DW-1:0] ed, input string tag);
    cyc(1, 0, 1, 1, en_of(b), AW'(a), 72'h0, drv, ed, tag);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      cur_item = exp_q.pop_front();
      vectors++;
      if (dq_oe !== cur_item.drv || (cur_item.drv && dq_out !== cur_item.d)) begin
        fails++;
        $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                 cur_item.tag, dq_oe, dq_out, cur_item.drv, cur_item.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; gw_n = 1; ads_p_n = 1; ads_c_n = 1; adv_n = 1; interleave = 0;
    oe_n = 0; snooze = 2'b00; addr_in = '0; bank_en_n = 2'b11; wdata = '0;
    cyc(1, 1, 1, 1, 2'b11, 0, 0, 0, '0, "R13");
    cyc(0, 0, 1, 1, 2'b10, 0, 0, 0, '0, "R13");
    rst = 0;

    // R11 R12: synchronous-only writes then reads, both banks
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) begin
        swr(b, k, pat(b, k), "R3");
        swr(b, 'h40 + k, pat(b, 'h40 + k), "R3");
      end
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) begin
        srd(b, k, 1, pat(b, k), "R11");
        srd(b, 'h40 + k, 1, pat(b, 'h40 + k), "R12");
      end

    // R2: processor start with write low; R1/R8/R7: linear burst ignores addr_in, wraps
    cyc(0, 0, 1, 0, 2'b10, 8'h42, 72'h1, 1, pat(0, 'h42), "R2");
    cyc(1, 1, 0, 1, 2'b11, 8'hFF, 0, 1, pat(0, 'h43), "R1");
    cyc(1, 1, 0, 1, 2'b11, 8'h13, 0, 1, pat(0, 'h40), "R8");
    cyc(1, 1, 0, 1, 2'b11, 8'h27, 0, 1, pat(0, 'h41), "R8");
    cyc(1, 1, 0, 1, 2'b11, 8'h00, 0, 1, pat(0, 'h42), "R7");

    // R8: interleaved order from low bits 01 -> 01,00,11,10
    interleave = 1;
    cyc(0, 1, 1, 1, 2'b01, 8'h05, 0, 1, pat(1, 5), "R2");
    cyc(1, 1, 0, 1, 2'b11, 8'h00, 0, 1, pat(1, 4), "R8");
    cyc(1, 1, 0, 1, 2'b11, 8'h00, 0, 1, pat(1, 7), "R8");
    cyc(1, 1, 0, 1, 2'b11, 8'h00, 0, 1, pat(1, 6), "R8");
    interleave = 0;

    // R6: wait holds the address; R5: advance afterwards
    cyc(0, 1, 1, 1, 2'b10, 8'h01, 0, 1, pat(0, 1), "R2");
    cyc(1, 1, 1, 1, 2'b11, 8'h07, 0, 1, pat(0, 1), "R6");
    cyc(1, 1, 1, 1, 2'b11, 8'h07, 0, 1, pat(0, 1), "R6");
    cyc(1, 1, 0, 1, 2'b11, 8'h07, 0, 1, pat(0, 2), "R5");

    // R9: output enable high blanks a read
    oe_n = 1;
    cyc(1, 1, 1, 1, 2'b11, 0, 0, 0, '0, "R9");
    oe_n = 0;
    cyc(1, 1, 1, 1, 2'b11, 0, 0, 1, pat(0, 2), "R9");

    // R4: deselect, then continues stay deselected
    cyc(1, 0, 1, 1, 2'b11, 8'h10, 0, 0, '0, "R4");
    cyc(1, 1, 0, 1, 2'b11, 8'h10, 0, 0, '0, "R4");
    cyc(1, 0, 1, 1, 2'b00, 8'h10, 0, 0, '0, "R4");

    // R5: burst write via controller strobe, linear from 0x46
    cyc(1, 0, 1, 0, 2'b01, 8'h46, {8'hE1, 64'h1111_2222_3333_4444}, 0, '0, "R3");
    cyc(1, 1, 0, 0, 2'b11, 8'h00, {8'hE2, 64'h5555_6666_7777_8888}, 0, '0, "R5");
    cyc(1, 1, 0, 0, 2'b11, 8'h00, {8'hE3, 64'h9999_AAAA_BBBB_CCCC}, 0, '0, "R5");
    srd(1, 'h46, 1, {8'hE1, 64'h1111_2222_3333_4444}, "R3");
    srd(1, 'h47, 1, {8'hE2, 64'h5555_6666_7777_8888}, "R5");
    srd(1, 'h44, 1, {8'hE3, 64'h9999_AAAA_BBBB_CCCC}, "R5");
    srd(1, 'h45, 1, pat(1, 'h45), "R7");
    srd(0, 'h42, 1, pat(0, 'h42), "R2");

    // R10: snoozed bank 0 drops writes and stays silent; bank 1 works
    snooze = 2'b01;
    swr(0, 0, {8'h77, 64'hDEAD_BEEF_0000_0001}, "R10");
    srd(0, 0, 0, '0, "R10");
    srd(1, 3, 1, pat(1, 3), "R10");
    snooze = 2'b00;
    srd(0, 0, 1, pat(0, 0), "R10");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule